// File: doc/BRIEF.md
# Multiplexed External Memory Bus Master

This block connects a processor core to off-chip memory over a narrow, time-shared pin set. The core presents one read or write at a time with a level request and receives a single-cycle acknowledge. Every transfer begins with an address cycle, marked by an address-latch-enable pulse, on the shared address/data lines. A data cycle follows with an active-low output-enable (read) or write strobe. Upper and lower byte-select strobes and a separate byte-address line (the least-significant bit of a 21-bit byte address) let the same bus reach bytes inside 16-bit words.

Static configuration inputs select the data width (8 or 16 bits), the address width (8, 12, 16 or 20 lines) and a wait count of 0 to 3 cycles. They are captured while reset is held and are ignored afterwards. The usual tie-off is 16-bit data, 20-bit address and a wait count of 3. Each of the 20 bus lines has an out, an output-enable and an in signal. Lines that the chosen address width does not need belong to a general-purpose I/O path. Lines the bus owns either float or, when the bus-disable input is set, are lent to that path between transfers.

Top module: `xbus_master`

## Requirements
- R1: `own_mask` marks the lines the bus uses. Line k is AD k for k<16 and the high address line k for k≥16. The address-width code maps as follows: 2'b11 gives 20 lines (20'hFFFFF), 2'b10 gives 16, 2'b01 gives 12, and 2'b00 gives 8. Only owned lines carry bus traffic.
- R2: Width, wait-enable and wait-count inputs are captured on clock edges with `rst_n` low. Changing them after reset has no effect on the mask or on transfer timing.
- R3: One cycle after a request is seen while idle, `ale` is high for exactly one cycle. In that cycle every owned line k drives bit k+1 of the byte address, and `ba0` carries address bit 0 for the whole transfer.
- R4: The data cycle lasts 1+N cycles, where N is the wait count (0 when waits are disabled). `ack` is high only in its last cycle, for one cycle.
- R5: In a read data cycle, `oe_n` is low and owned data lines are not driven. `rdata` returns the lines in the acknowledge cycle: 16-bit word gives AD15:0, byte gives the lane picked by address bit 0 in bits 7:0, and 8-bit data gives AD7:0. The remaining bits are zero.
- R6: In a write data cycle, `wr_n` is low and owned data lines carry the write data: the full word for a 16-bit word write, otherwise wdata[7:0] on each lane. `oe_n` and `wr_n` are never low together.
- R7: Owned lines that are not data lines (AD15:8 with 8-bit data, the high address lines always) keep the address through the data cycle.
- R8: With 16-bit data and an 8- or 12-line address, the unowned upper data lines are never driven by the bus, and their bits read back as zero.
- R9: In the data cycle, with 16-bit data, a word transfer pulls both `ub_n` and `lb_n` low. A byte transfer pulls `lb_n` low for address bit 0 = 0 and `ub_n` low for address bit 0 = 1. With 8-bit data only `lb_n` goes low. Both are high outside the data cycle.
- R10: Lines that are not owned always follow `gp_out`/`gp_oe`, whatever `bus_dis` is. Owned lines between transfers float when `bus_dis` is low and follow `gp_out`/`gp_oe` when it is high. `gp_in` always mirrors `pad_i`.
- R11: After reset the block is idle: `ack` and `ale` are low, every strobe is high, and no owned line is driven when `bus_dis` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, also captures configuration |
| cfg_dw16 | input | 1 | 1 = 16-bit data, 0 = 8-bit data |
| cfg_aw | input | 2 | Address-width code |
| cfg_wait_en | input | 1 | Enable wait cycles |
| cfg_wait | input | 2 | Wait-cycle count |
| req | input | 1 | Transfer request, held until ack |
| we | input | 1 | 1 = write, 0 = read |
| word | input | 1 | 1 = 16-bit word, 0 = byte |
| addr | input | 21 | Byte address |
| wdata | input | 16 | Write data |
| ack | output | 1 | Transfer done, one cycle |
| rdata | output | 16 | Read data, valid with ack |
| bus_dis | input | 1 | Lend owned lines to general I/O while idle |
| own_mask | output | 20 | Lines owned by the bus |
| ale | output | 1 | Address latch enable |
| oe_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| ub_n | output | 1 | Upper byte select, active low |
| lb_n | output | 1 | Lower byte select, active low |
| ba0 | output | 1 | Byte address bit 0 |
| pad_o | output | 20 | Line output values |
| pad_oe | output | 20 | Line output enables |
| pad_i | input | 20 | Line input values |
| gp_out | input | 20 | General I/O output values |
| gp_oe | input | 20 | General I/O output enables |
| gp_in | output | 20 | General I/O input values |

## Verification
The bench runs word writes, word reads and byte accesses to both lanes under five width and wait settings. Comparing these cases separates lane steering, strobe choice and the address-only lines from the data lines. Back-to-back requests and wait counts of 0, 1, 2 and 3 pin down where `ack` falls. Idle stretches with `bus_dis` toggled and changing general I/O patterns separate owned lines from released ones. A configuration change without reset shows that the captured settings stay in force.

// File: rtl/xbus_master.sv
module xbus_master (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_dw16,
  input  logic [1:0]  cfg_aw,
  input  logic        cfg_wait_en,
  input  logic [1:0]  cfg_wait,
  input  logic        req,
  input  logic        we,
  input  logic        word,
  input  logic [20:0] addr,
  input  logic [15:0] wdata,
  output logic        ack,
  output logic [15:0] rdata,
  input  logic        bus_dis,
  output logic [19:0] own_mask,
  output logic        ale,
  output logic        oe_n,
  output logic        wr_n,
  output logic        ub_n,
  output logic        lb_n,
  output logic        ba0,
  output logic [19:0] pad_o,
  output logic [19:0] pad_oe,
  input  logic [19:0] pad_i,
  input  logic [19:0] gp_out,
  input  logic [19:0] gp_oe,
  output logic [19:0] gp_in
);

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA} st_t;

  st_t         st;
  logic [1:0]  cnt;
  logic        dw16_q;
  logic [1:0]  aw_q, nw_q;
  logic        we_q, word_q;
  logic [20:0] addr_q;
  logic [15:0] wdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dw16_q <= cfg_dw16;
      aw_q   <= cfg_aw;
      nw_q   <= cfg_wait_en ? cfg_wait : 2'd0;
      st     <= S_IDLE;
      cnt    <= 2'd0;
    end else begin
      case (st)
        S_IDLE: if (req) st <= S_ADDR;
        S_ADDR: begin
          st  <= S_DATA;
          cnt <= nw_q;
        end
        S_DATA: begin
          if (cnt == 2'd0) st <= S_IDLE;
          else cnt <= cnt - 2'd1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_IDLE && req) begin
      we_q    <= we;
      word_q  <= word;
      addr_q  <= addr;
      wdata_q <= wdata;
    end
  end

  always_comb begin
    case (aw_q)
      2'b11:   own_mask = 20'hFFFFF;
      2'b10:   own_mask = 20'h0FFFF;
      2'b01:   own_mask = 20'h00FFF;
      default: own_mask = 20'h000FF;
    endcase
  end

  logic        busy, in_data;
  logic [19:0] dmask, laned, bus_o, bus_oe, sel_gp;

  assign busy    = (st != S_IDLE);
  assign in_data = (st == S_DATA);
  assign dmask   = {4'h0, own_mask[15:8] & {8{dw16_q}}, own_mask[7:0]};
  assign laned   = {4'h0, (dw16_q && word_q) ? wdata_q : {wdata_q[7:0], wdata_q[7:0]}};

  always_comb begin
    bus_o  = 20'h0;
    bus_oe = 20'h0;
    if (st == S_ADDR) begin
      bus_o  = addr_q[20:1];
      bus_oe = 20'hFFFFF;
    end else if (in_data) begin
      bus_o  = (dmask & laned) | (~dmask & addr_q[20:1]);
      bus_oe = we_q ? 20'hFFFFF : ~dmask;
    end
  end

  assign sel_gp = ~own_mask | {20{~busy & bus_dis}};
  assign pad_o  = (sel_gp & gp_out) | (~sel_gp & bus_o);
  assign pad_oe = (sel_gp & gp_oe)  | (~sel_gp & bus_oe);
  assign gp_in  = pad_i;

  assign ale  = (st == S_ADDR);
  assign ack  = in_data && (cnt == 2'd0);
  assign oe_n = !(in_data && !we_q);
  assign wr_n = !(in_data && we_q);
  assign ba0  = busy && addr_q[0];
  assign ub_n = !(in_data && dw16_q && (word_q || addr_q[0]));
  assign lb_n = !(in_data && (!dw16_q || word_q || !addr_q[0]));

  always_comb begin
    if (!dw16_q)     rdata = {8'h0, pad_i[7:0]};
    else if (word_q) rdata = pad_i[15:0] & dmask[15:0];
    else if (addr_q[0]) rdata = {8'h0, pad_i[15:8] & dmask[15:8]};
    else             rdata = {8'h0, pad_i[7:0]};
  end

  p_ale_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);
  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n && !wr_n));
  p_ack_in_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (!oe_n || !wr_n));
  p_ack_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
  p_hi_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (own_mask[19] && (!oe_n || !wr_n)) |-> $stable(pad_o[19:16]));
  p_idle_float_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_n && wr_n && !ale && !bus_dis) |-> ((pad_oe & own_mask) == 20'h0));
  p_cfg_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(own_mask));

endmodule

// File: tb/sim_xbus_master.sv
module sim_xbus_master;
  logic clk = 0;
  always #4 clk = ~clk;

  logic        rst_n, cfg_dw16, cfg_wait_en, req, we, word, bus_dis;
  logic [1:0]  cfg_aw, cfg_wait;
  logic [20:0] addr;
  logic [15:0] wdata;
  logic [19:0] pad_i, gp_out, gp_oe;
  logic        ack, ale, oe_n, wr_n, ub_n, lb_n, ba0;
  logic [15:0] rdata;
  logic [19:0] own_mask, pad_o, pad_oe, gp_in;

  xbus_master u0 (.clk(clk), .rst_n(rst_n), .cfg_dw16(cfg_dw16), .cfg_aw(cfg_aw),
    .cfg_wait_en(cfg_wait_en), .cfg_wait(cfg_wait), .req(req), .we(we), .word(word),
    .addr(addr), .wdata(wdata), .ack(ack), .rdata(rdata), .bus_dis(bus_dis),
    .own_mask(own_mask), .ale(ale), .oe_n(oe_n), .wr_n(wr_n), .ub_n(ub_n), .lb_n(lb_n),
    .ba0(ba0), .pad_o(pad_o), .pad_oe(pad_oe), .pad_i(pad_i), .gp_out(gp_out),
    .gp_oe(gp_oe), .gp_in(gp_in));

  int n_chk = 0, n_err = 0;
  bit done = 0, cmp_en = 0, last_ack = 0;

  // reference model state
  int          m_phase = 0;   // 0 idle, 1 address, 2 data
  int          m_cnt = 0, m_nw = 0;
  logic        m_dw16, m_we, m_word;
  logic [19:0] m_own;
  logic [20:0] m_addr;
  logic [15:0] m_wdata;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s at %0t: got %h expected %h", tag, $time, act, exp);
    end
  endtask

  task automatic compare();
    logic [19:0] e_o, e_oe;
    logic [15:0] lane, e_rd;
    logic e_ack, narrow;
    narrow = m_dw16 && !m_own[15];
    lane = (m_dw16 && m_word) ? m_wdata : {m_wdata[7:0], m_wdata[7:0]};
    e_ack = (m_phase == 2 && m_cnt == 0);
    chk("R1", own_mask, m_own);
    chk("R3", {ale, ba0}, {m_phase == 1, m_phase != 0 && m_addr[0]});
    chk("R4", ack, e_ack);
    chk("R5", oe_n, !(m_phase == 2 && !m_we));
    chk("R6", wr_n, !(m_phase == 2 && m_we));
    if (m_phase == 2)
      chk("R9", {ub_n, lb_n}, !m_dw16 ? 2'b10 : m_word ? 2'b00 : m_addr[0] ? 2'b01 : 2'b10);
    else
      chk("R9", {ub_n, lb_n}, 2'b11);
    for (int k = 0; k < 20; k++) begin
      if (!m_own[k] || (m_phase == 0 && bus_dis)) begin
        e_o[k] = gp_out[k]; e_oe[k] = gp_oe[k];
      end else if (m_phase == 0) begin
        e_o[k] = 1'b0; e_oe[k] = 1'b0;
      end else if (m_phase == 1 || k >= (m_dw16 ? 16 : 8)) begin
        e_o[k] = m_addr[k+1]; e_oe[k] = 1'b1;
      end else begin
        e_o[k] = lane[k]; e_oe[k] = m_we;
      end
    end
    chk(m_phase == 0 ? "R10" : m_phase == 1 ? "R3" : narrow ? "R8" : "R7", pad_oe, e_oe);
    chk(m_phase == 0 ? "R10" : m_phase == 1 ? "R3" : narrow ? "R8" : "R7",
        pad_o & e_oe, e_o & e_oe);
    chk("R10", gp_in, pad_i);
    if (e_ack && !m_we) begin
      if (!m_dw16) e_rd = {8'h0, pad_i[7:0]};
      else if (m_word) e_rd = pad_i[15:0] & m_own[15:0];
      else if (m_addr[0]) e_rd = {8'h0, pad_i[15:8] & m_own[15:8]};
      else e_rd = {8'h0, pad_i[7:0]};
      chk(narrow ? "R8" : "R5", rdata, e_rd);
    end
  endtask

  task automatic tick();
    #1;
    if (cmp_en) compare();
    @(posedge clk);
    last_ack = (m_phase == 2 && m_cnt == 0);
    if (!rst_n) begin
      m_dw16 = cfg_dw16;
      m_nw = cfg_wait_en ? int'(cfg_wait) : 0;
      case (cfg_aw)
        2'b11: m_own = 20'hFFFFF;
        2'b10: m_own = 20'h0FFFF;
        2'b01: m_own = 20'h00FFF;
        default: m_own = 20'h000FF;
      endcase
      m_phase = 0; m_cnt = 0;
    end else if (m_phase == 0) begin
      if (req) begin
        m_phase = 1; m_we = we; m_word = word; m_addr = addr; m_wdata = wdata;
      end
    end else if (m_phase == 1) begin
      m_phase = 2; m_cnt = m_nw;
    end else if (m_cnt == 0) m_phase = 0;
    else m_cnt--;
    @(negedge clk);
  endtask

  task automatic do_reset(logic dw16, logic [1:0] aw, logic wen, logic [1:0] wc);
    cmp_en = 0;
    cfg_dw16 = dw16; cfg_aw = aw; cfg_wait_en = wen; cfg_wait = wc;
    rst_n = 0; bus_dis = 0; req = 0;
    repeat (3) tick();
    rst_n = 1;
    #1;
    // R11: idle after reset
    chk("R11", {ack, ale, oe_n, wr_n, ub_n, lb_n}, 6'b001111);
    chk("R11", pad_oe & own_mask, 20'h0);
    @(negedge clk);
    cmp_en = 1;
  endtask

  task automatic xfer(logic w, logic wd, logic [20:0] a, logic [15:0] d);
    req = 1; we = w; word = wd; addr = a; wdata = d;
    do tick(); while (!last_ack);
    req = 0; addr = 21'h0; wdata = 16'h0;
  endtask

  task automatic idle(int n, logic dis, logic [19:0] go, logic [19:0] ge);
    bus_dis = dis; gp_out = go; gp_oe = ge;
    repeat (n) tick();
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin @(posedge clk); cyc++; end
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    req = 0; we = 0; word = 0; addr = 0; wdata = 0; bus_dis = 0;
    pad_i = 20'h5C3A1; gp_out = 20'hA5C3F; gp_oe = 20'h0F0F0; rst_n = 0;
    @(negedge clk);

    // 16-bit data, 20 lines, 3 waits (R4 longest data cycle)
    do_reset(1'b1, 2'b11, 1'b1, 2'd3);
    idle(2, 1'b0, 20'h12345, 20'hFFFFF);
    xfer(1, 1, 21'h15A3C4, 16'hBEEF);
    xfer(0, 1, 21'h0A5F12, 16'h0);
    xfer(1, 0, 21'h1F0001, 16'h0077);       // R9 upper lane
    xfer(1, 0, 21'h1F0002, 16'h00C4);       // R9 lower lane
    pad_i = 20'hE7B6D;
    xfer(0, 0, 21'h000103, 16'h0);          // R5 upper byte read
    xfer(0, 0, 21'h000104, 16'h0);
    idle(3, 1'b1, 20'hFEDCB, 20'h3C3C3);    // R10 lent lines
    idle(2, 1'b0, 20'h01234, 20'hFFFFF);
    // R2: configuration change without reset is ignored
    cfg_dw16 = 0; cfg_aw = 2'b00; cfg_wait_en = 0;
    xfer(0, 1, 21'h1C0DE6, 16'h0);
    chk("R2", own_mask, 20'hFFFFF);

    // 8-bit data, 20 lines, waits disabled (R7 address-only AD15:8)
    do_reset(1'b0, 2'b11, 1'b0, 2'd3);
    xfer(1, 1, 21'h1ABCDE, 16'h9966);
    xfer(0, 0, 21'h0F00F1, 16'h0);
    xfer(1, 0, 21'h123457, 16'h0042);

    // 16-bit data, 8 lines, 1 wait (R8)
    do_reset(1'b1, 2'b00, 1'b1, 2'd1);
    pad_i = 20'hFA5C3;
    xfer(1, 1, 21'h1FFFFE, 16'hCAFE);
    xfer(0, 1, 21'h000F0E, 16'h0);
    xfer(0, 0, 21'h000F0F, 16'h0);
    idle(2, 1'b1, 20'h55555, 20'hAAAAA);
    idle(2, 1'b0, 20'hAAAAA, 20'h55555);

    // 16-bit data, 16 lines, 2 waits (R10 released high lines)
    do_reset(1'b1, 2'b10, 1'b1, 2'd2);
    idle(2, 1'b1, 20'hF0000, 20'hF0F00);
    xfer(0, 1, 21'h13579A, 16'h0);
    idle(1, 1'b0, 20'h0FFFF, 20'hF00FF);
    xfer(1, 0, 21'h02468B, 16'h00E1);

    // 8-bit data, 12 lines, 0 waits enabled
    do_reset(1'b0, 2'b01, 1'b1, 2'd0);
    xfer(1, 0, 21'h00ABC4, 16'h005A);
    xfer(0, 0, 21'h00ABC5, 16'h0);
    idle(2, 1'b1, 20'hBADC0, 20'hFFFFF);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule